// File: doc/BRIEF.md
# Serial Command Frame Codec with XOR Checksum

This block converts between a byte stream and whole command frames. Each frame starts with the sync value 0x02. The sync byte is followed by an operation group byte, an opcode byte, a payload length byte, that many payload bytes and a single check byte. The check byte is the XOR of every byte after the sync byte, up to and including the last payload byte.

The receive half watches an incoming byte stream and ignores everything until it sees a sync byte. It then captures the group, opcode and length into registers and writes the payload into a local buffer. When the check byte arrives, it raises a one-cycle completion strobe together with a pass/fail flag. The payload stays readable through a synchronous read port. A control input can turn verification off; the check position is then still consumed, but every frame is reported as passing.

The transmit half works from a parallel request. The host fills a payload buffer through a write port, then pulses a start input with the group, opcode and length. The block emits the complete frame, with its computed check byte, on a valid/ready byte stream.

Top module: `cmdframe_codec`

## Requirements
- R1: While searching for a frame start, the receiver drops every byte other than 0x02, and such bytes never produce a completion or overflow strobe.
- R2: After a frame completes, the receiver presents the captured group, opcode and length on its frame outputs, which hold until the next completion. Payload byte k (byte 0 is the one right after the length byte) is returned on the read-data output one cycle after its index is placed on the read address.
- R3: With verification on (chk_en=1), the pass flag at completion is 1 exactly when the received check byte equals the XOR of group, opcode, length and all payload bytes, with 0x02 excluded. For example, 95 0A 01 30 gives AE.
- R4: The completion strobe is high for exactly one cycle, the cycle after the check byte is accepted, for passing and failing frames alike.
- R5: A length of 0 is legal, and the byte following the length byte is then taken as the check byte.
- R6: A length above PAY_DEPTH raises a one-cycle overflow strobe in the cycle after the length byte is accepted. It produces no completion strobe, and the receiver returns to searching for 0x02.
- R7: With verification off (chk_en=0), the pass flag is 1 at every completion. The byte in the check position is still consumed, even when it equals 0x02.
- R8: A start request accepted while idle makes tx_valid rise in the next cycle with byte 0x02. It is followed by group, opcode, length, the first length bytes of the transmit buffer, and the XOR check byte, after which tx_valid falls.
- R9: While tx_valid is high and tx_ready is low, tx_byte and tx_valid hold. Exactly one byte advances per cycle in which both are high.
- R10: tf_busy is high from the cycle after an accepted start until the check byte is accepted. A start pulse while busy is ignored.
- R11: The transmitted check byte is the computed XOR whatever the value of chk_en.
- R12: rx_ready is low during reset and high in every cycle after it. After reset, the strobes, tx_valid and tf_busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chk_en | input | 1 | 1 = verify received check byte |
| rx_byte | input | 8 | Incoming stream byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Receiver accepts a byte |
| rf_done | output | 1 | One-cycle frame completion strobe |
| rf_good | output | 1 | Pass flag, meaningful with rf_done |
| rf_ovf | output | 1 | One-cycle length overflow strobe |
| rf_group | output | 8 | Group of the last completed frame |
| rf_opcode | output | 8 | Opcode of the last completed frame |
| rf_len | output | 8 | Length of the last completed frame |
| rf_rd_addr | input | AW | Receive payload read index |
| rf_rd_data | output | 8 | Receive payload byte, one cycle after address |
| tf_start | input | 1 | Start a transmit frame |
| tf_group | input | 8 | Group for the transmit frame |
| tf_opcode | input | 8 | Opcode for the transmit frame |
| tf_len | input | 8 | Payload length, at most PAY_DEPTH |
| tf_busy | output | 1 | Transmitter is sending a frame |
| tf_wr_en | input | 1 | Transmit buffer write strobe |
| tf_wr_addr | input | AW | Transmit buffer write index |
| tf_wr_data | input | 8 | Transmit buffer write byte |
| tx_byte | output | 8 | Outgoing stream byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Sink accepts the outgoing byte |

## Verification
The receive strobes follow one rising edge after the byte that causes them: rf_done and the frame fields after the check byte, and rf_ovf after an oversize length byte. rf_rd_data follows its address by one edge. On the transmit side, tx_valid and tf_busy rise one edge after an accepted start, and each new tx_byte appears on the edge that accepts the previous one. Inputs change only at falling edges. At every falling edge the bench advances a behavioural queue model by the inputs the preceding rising edge saw, and compares every output against it there. Stimulus covers junk before sync, bad and good check bytes, zero and full-depth lengths, oversize lengths, disabled verification with a check byte of 0x02, back-pressure, and start pulses while busy.

// File: rtl/cmdframe_pkg.sv
package cmdframe_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h02;

  typedef enum logic [2:0] {
    R_HUNT, R_GRP, R_OPC, R_LEN, R_PAY, R_SUM
  } rx_state_e;

  typedef enum logic [2:0] {
    T_IDLE, T_SYNC, T_GRP, T_OPC, T_LEN, T_PAY, T_SUM
  } tx_state_e;
endpackage

// File: rtl/cmdframe_rx.sv
module cmdframe_rx
  import cmdframe_pkg::*;
#(
  parameter int PAY_DEPTH = 16,
  localparam int AW = (PAY_DEPTH > 1) ? $clog2(PAY_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chk_en,
  input  logic [7:0]    rx_byte,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic          rf_done,
  output logic          rf_good,
  output logic          rf_ovf,
  output logic [7:0]    rf_group,
  output logic [7:0]    rf_opcode,
  output logic [7:0]    rf_len,
  input  logic [AW-1:0] rf_rd_addr,
  output logic [7:0]    rf_rd_data
);
  localparam logic [8:0] DEPTH_W = 9'(PAY_DEPTH);

  rx_state_e  st;
  logic [7:0] grp_q, opc_q, len_q, cnt, sum;
  logic       acc, wr;
  logic [7:0] buf_mem [PAY_DEPTH];

  assign acc = rx_valid & rx_ready;
  assign wr  = acc && (st == R_PAY);

  // payload buffer, synchronous read for block RAM inference
  always_ff @(posedge clk) begin
    if (wr) buf_mem[cnt[AW-1:0]] <= rx_byte;
    rf_rd_data <= buf_mem[rf_rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= R_HUNT;
      rx_ready  <= 1'b0;
      rf_done   <= 1'b0;
      rf_good   <= 1'b0;
      rf_ovf    <= 1'b0;
      rf_group  <= '0;
      rf_opcode <= '0;
      rf_len    <= '0;
      grp_q     <= '0;
      opc_q     <= '0;
      len_q     <= '0;
      cnt       <= '0;
      sum       <= '0;
    end else begin
      rx_ready <= 1'b1;
      rf_done  <= 1'b0;
      rf_ovf   <= 1'b0;
      if (acc) begin
        case (st)
          R_HUNT: if (rx_byte == SYNC_BYTE) st <= R_GRP;
          R_GRP: begin
            grp_q <= rx_byte;
            sum   <= rx_byte;
            st    <= R_OPC;
          end
          R_OPC: begin
            opc_q <= rx_byte;
            sum   <= sum ^ rx_byte;
            st    <= R_LEN;
          end
          R_LEN: begin
            len_q <= rx_byte;
            sum   <= sum ^ rx_byte;
            cnt   <= '0;
            if ({1'b0, rx_byte} > DEPTH_W) begin
              rf_ovf <= 1'b1;
              st     <= R_HUNT;
            end else if (rx_byte == 8'd0) begin
              st <= R_SUM;
            end else begin
              st <= R_PAY;
            end
          end
          R_PAY: begin
            sum <= sum ^ rx_byte;
            cnt <= cnt + 8'd1;
            if (cnt + 8'd1 == len_q) st <= R_SUM;
          end
          R_SUM: begin
            rf_done   <= 1'b1;
            rf_good   <= !chk_en || (rx_byte == sum);
            rf_group  <= grp_q;
            rf_opcode <= opc_q;
            rf_len    <= len_q;
            st        <= R_HUNT;
          end
          default: st <= R_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdframe_tx.sv
module cmdframe_tx
  import cmdframe_pkg::*;
#(
  parameter int PAY_DEPTH = 16,
  localparam int AW = (PAY_DEPTH > 1) ? $clog2(PAY_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tf_start,
  input  logic [7:0]    tf_group,
  input  logic [7:0]    tf_opcode,
  input  logic [7:0]    tf_len,
  output logic          tf_busy,
  input  logic          tf_wr_en,
  input  logic [AW-1:0] tf_wr_addr,
  input  logic [7:0]    tf_wr_data,
  output logic [7:0]    tx_byte,
  output logic          tx_valid,
  input  logic          tx_ready
);
  tx_state_e  st;
  logic [7:0] grp_q, opc_q, len_q, idx, sum, mem_q;
  logic [AW-1:0] ptr;
  logic       fire;
  logic [7:0] buf_mem [PAY_DEPTH];

  assign fire    = tx_valid & tx_ready;
  assign tf_busy = (st != T_IDLE);

  // read one entry ahead so the next payload byte is ready at each handshake
  always_comb begin
    if (fire && (st == T_LEN || st == T_PAY)) ptr = AW'(idx + 8'd1);
    else                                      ptr = AW'(idx);
  end

  always_ff @(posedge clk) begin
    if (tf_wr_en) buf_mem[tf_wr_addr] <= tf_wr_data;
    mem_q <= buf_mem[ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= T_IDLE;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      grp_q    <= '0;
      opc_q    <= '0;
      len_q    <= '0;
      idx      <= '0;
      sum      <= '0;
    end else begin
      case (st)
        T_IDLE: if (tf_start) begin
          grp_q    <= tf_group;
          opc_q    <= tf_opcode;
          len_q    <= tf_len;
          idx      <= '0;
          tx_byte  <= SYNC_BYTE;
          tx_valid <= 1'b1;
          st       <= T_SYNC;
        end
        T_SYNC: if (fire) begin
          tx_byte <= grp_q;
          sum     <= grp_q;
          st      <= T_GRP;
        end
        T_GRP: if (fire) begin
          tx_byte <= opc_q;
          sum     <= sum ^ opc_q;
          st      <= T_OPC;
        end
        T_OPC: if (fire) begin
          tx_byte <= len_q;
          sum     <= sum ^ len_q;
          st      <= T_LEN;
        end
        T_LEN: if (fire) begin
          if (len_q == 8'd0) begin
            tx_byte <= sum;
            st      <= T_SUM;
          end else begin
            tx_byte <= mem_q;
            sum     <= sum ^ mem_q;
            idx     <= 8'd1;
            st      <= T_PAY;
          end
        end
        T_PAY: if (fire) begin
          if (idx == len_q) begin
            tx_byte <= sum;
            st      <= T_SUM;
          end else begin
            tx_byte <= mem_q;
            sum     <= sum ^ mem_q;
            idx     <= idx + 8'd1;
          end
        end
        T_SUM: if (fire) begin
          tx_valid <= 1'b0;
          st       <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdframe_codec.sv
module cmdframe_codec #(
  parameter int PAY_DEPTH = 16,
  localparam int AW = (PAY_DEPTH > 1) ? $clog2(PAY_DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chk_en,
  input  logic [7:0]    rx_byte,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic          rf_done,
  output logic          rf_good,
  output logic          rf_ovf,
  output logic [7:0]    rf_group,
  output logic [7:0]    rf_opcode,
  output logic [7:0]    rf_len,
  input  logic [AW-1:0] rf_rd_addr,
  output logic [7:0]    rf_rd_data,
  input  logic          tf_start,
  input  logic [7:0]    tf_group,
  input  logic [7:0]    tf_opcode,
  input  logic [7:0]    tf_len,
  output logic          tf_busy,
  input  logic          tf_wr_en,
  input  logic [AW-1:0] tf_wr_addr,
  input  logic [7:0]    tf_wr_data,
  output logic [7:0]    tx_byte,
  output logic          tx_valid,
  input  logic          tx_ready
);
  cmdframe_rx #(.PAY_DEPTH(PAY_DEPTH)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .chk_en     (chk_en),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rf_done    (rf_done),
    .rf_good    (rf_good),
    .rf_ovf     (rf_ovf),
    .rf_group   (rf_group),
    .rf_opcode  (rf_opcode),
    .rf_len     (rf_len),
    .rf_rd_addr (rf_rd_addr),
    .rf_rd_data (rf_rd_data)
  );

  cmdframe_tx #(.PAY_DEPTH(PAY_DEPTH)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .tf_start   (tf_start),
    .tf_group   (tf_group),
    .tf_opcode  (tf_opcode),
    .tf_len     (tf_len),
    .tf_busy    (tf_busy),
    .tf_wr_en   (tf_wr_en),
    .tf_wr_addr (tf_wr_addr),
    .tf_wr_data (tf_wr_data),
    .tx_byte    (tx_byte),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready)
  );
endmodule

// File: rtl/cmdframe_codec_chk.sv
module cmdframe_codec_chk (
  input logic       clk,
  input logic       rst,
  input logic       chk_en,
  input logic       rx_ready,
  input logic       rf_done,
  input logic       rf_good,
  input logic       rf_ovf,
  input logic       tf_start,
  input logic       tf_busy,
  input logic [7:0] tx_byte,
  input logic       tx_valid,
  input logic       tx_ready
);
  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rf_done |=> !rf_done);

  // R6
  ovf_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rf_ovf |-> !rf_done);

  // R7
  nochk_good_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_done && !$past(chk_en)) |-> rf_good);

  // R8
  tx_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> (tx_byte == 8'h02));

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  // R10
  tx_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!tf_busy && tf_start) |=> (tf_busy && tx_valid));

  // R12
  rx_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_ready |=> rx_ready);
endmodule

bind cmdframe_codec cmdframe_codec_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .chk_en   (chk_en),
  .rx_ready (rx_ready),
  .rf_done  (rf_done),
  .rf_good  (rf_good),
  .rf_ovf   (rf_ovf),
  .tf_start (tf_start),
  .tf_busy  (tf_busy),
  .tx_byte  (tx_byte),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready)
);

// File: tb/cmdframe_codec_test.sv
module cmdframe_codec_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chk_en = 1'b1;
  logic [7:0] rx_byte = '0;
  logic rx_valid = 1'b0;
  logic rx_ready, rf_done, rf_good, rf_ovf;
  logic [7:0] rf_group, rf_opcode, rf_len, rf_rd_data;
  logic [AW-1:0] rf_rd_addr = '0;
  logic tf_start = 1'b0;
  logic [7:0] tf_group = '0, tf_opcode = '0, tf_len = '0;
  logic tf_busy;
  logic tf_wr_en = 1'b0;
  logic [AW-1:0] tf_wr_addr = '0;
  logic [7:0] tf_wr_data = '0;
  logic [7:0] tx_byte;
  logic tx_valid;
  logic tx_ready = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmdframe_codec #(.PAY_DEPTH(DEPTH)) uut (.*);

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit bp_on = 1'b0;
  string rx_tag = "R4";
  string tx_tag = "R8";

  // behavioural reference state
  int m_phase = 0;
  int m_cnt = 0;
  logic [7:0] m_g, m_o, m_l, m_x;
  logic m_rdy = 0, m_done = 0, m_good = 0, m_ovf = 0;
  string m_good_tag = "R3";
  logic [7:0] o_g = 0, o_o = 0, o_l = 0;
  logic [7:0] m_rxmem [DEPTH];
  bit m_rxwr [DEPTH];
  logic [7:0] m_rd;
  bit m_rd_ok = 0;
  logic [7:0] m_txmem [DEPTH];
  logic [7:0] txq [$];

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit busy_before;
    m_rd = m_rxmem[rf_rd_addr];
    m_rd_ok = m_rxwr[rf_rd_addr];
    if (tf_wr_en) m_txmem[tf_wr_addr] = tf_wr_data;
    if (rst) begin
      m_rdy = 0; m_done = 0; m_ovf = 0; m_good = 0;
      o_g = 0; o_o = 0; o_l = 0; m_phase = 0;
      txq.delete();
      return;
    end
    m_done = 0;
    m_ovf = 0;
    if (m_rdy && rx_valid) begin
      case (m_phase)
        0: if (rx_byte == 8'h02) m_phase = 1;
        1: begin m_g = rx_byte; m_x = rx_byte; m_phase = 2; end
        2: begin m_o = rx_byte; m_x ^= rx_byte; m_phase = 3; end
        3: begin
          m_l = rx_byte; m_x ^= rx_byte; m_cnt = 0;
          if (int'(rx_byte) > DEPTH) begin m_ovf = 1; m_phase = 0; end
          else if (rx_byte == 0) m_phase = 5;
          else m_phase = 4;
        end
        4: begin
          m_rxmem[m_cnt] = rx_byte; m_rxwr[m_cnt] = 1;
          m_x ^= rx_byte; m_cnt++;
          if (m_cnt == int'(m_l)) m_phase = 5;
        end
        default: begin
          m_done = 1;
          m_good = !chk_en || (rx_byte == m_x);
          m_good_tag = chk_en ? "R3" : "R7";
          o_g = m_g; o_o = m_o; o_l = m_l;
          m_phase = 0;
        end
      endcase
    end
    m_rdy = 1;
    busy_before = (txq.size() > 0);
    if (busy_before && tx_ready) void'(txq.pop_front());
    if (!busy_before && tf_start) begin
      logic [7:0] x;
      x = tf_group ^ tf_opcode ^ tf_len;
      txq.push_back(8'h02);
      txq.push_back(tf_group);
      txq.push_back(tf_opcode);
      txq.push_back(tf_len);
      for (int i = 0; i < int'(tf_len); i++) begin
        txq.push_back(m_txmem[i]);
        x ^= m_txmem[i];
      end
      txq.push_back(x);
    end
  endtask

  task automatic compare();
    chk("R12", "rx_ready", {7'd0, rx_ready}, {7'd0, m_rdy});
    chk(rx_tag, "rf_done", {7'd0, rf_done}, {7'd0, m_done});
    chk("R6", "rf_ovf", {7'd0, rf_ovf}, {7'd0, m_ovf});
    if (m_done) chk(m_good_tag, "rf_good", {7'd0, rf_good}, {7'd0, m_good});
    chk("R2", "rf_group", rf_group, o_g);
    chk("R2", "rf_opcode", rf_opcode, o_o);
    chk("R2", "rf_len", rf_len, o_l);
    if (m_rd_ok) chk("R2", "rf_rd_data", rf_rd_data, m_rd);
    chk(tx_tag, "tx_valid", {7'd0, tx_valid}, {7'd0, txq.size() > 0});
    if (txq.size() > 0) chk(tx_tag, "tx_byte", tx_byte, txq[0]);
    chk("R10", "tf_busy", {7'd0, tf_busy}, {7'd0, txq.size() > 0});
  endtask

  task automatic tick();
    @(negedge clk);
    step();
    compare();
    cyc++;
    tx_ready = !bp_on || (cyc % 3 != 0);
    rf_rd_addr = AW'(cyc % DEPTH);
  endtask

  task automatic rx_send(input logic [7:0] b);
    rx_byte = b;
    rx_valid = 1'b1;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic tx_write(input int a, input logic [7:0] d);
    tf_wr_en = 1'b1;
    tf_wr_addr = AW'(a);
    tf_wr_data = d;
    tick();
    tf_wr_en = 1'b0;
  endtask

  task automatic tx_go(input logic [7:0] g, input logic [7:0] o, input logic [7:0] l);
    tf_start = 1'b1;
    tf_group = g;
    tf_opcode = o;
    tf_len = l;
    tick();
    tf_start = 1'b0;
  endtask

  task automatic tx_drain();
    while (txq.size() > 0) tick();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] x;
    for (int i = 0; i < DEPTH; i++) m_rxwr[i] = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R12 reset state
    chk("R12", "reset rf_done", {7'd0, rf_done}, 8'd0);
    chk("R12", "reset tx_valid", {7'd0, tx_valid}, 8'd0);
    chk("R12", "reset rx_ready", {7'd0, rx_ready}, 8'd1);

    // R1 junk before sync
    rx_tag = "R1";
    rx_send(8'h11); rx_send(8'h55); rx_send(8'hAB); tick();
    // R3 R4 known-good frame
    rx_tag = "R4";
    rx_send(8'h02); rx_send(8'h95); rx_send(8'h0A); rx_send(8'h01);
    rx_send(8'h30); rx_send(8'hAE); tick();
    chk("R3", "example frame good", {7'd0, rf_good}, 8'd1);
    // R3 bad check byte
    rx_send(8'h02); rx_send(8'h95); rx_send(8'h0A); rx_send(8'h01);
    rx_send(8'h30); rx_send(8'hAF); tick();
    // R5 zero length
    rx_tag = "R5";
    rx_send(8'h02); rx_send(8'h10); rx_send(8'h20); rx_send(8'h00);
    rx_send(8'h30); tick(); tick();
    // R6 oversize length, then a good frame
    rx_tag = "R6";
    rx_send(8'h02); rx_send(8'h01); rx_send(8'h02); rx_send(8'(DEPTH + 1));
    rx_send(8'h02); rx_send(8'h05); rx_send(8'h06); rx_send(8'h02);
    rx_send(8'hAA); rx_send(8'hBB); rx_send(8'h10); tick();
    // R2 full-depth frame with idle gaps
    rx_tag = "R2";
    x = 8'h3C ^ 8'hC3 ^ 8'(DEPTH);
    rx_send(8'h02); rx_send(8'h3C); rx_send(8'hC3); rx_send(8'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      rx_send(8'(i * 7 + 1));
      x ^= 8'(i * 7 + 1);
      if (i % 2 == 0) tick();
    end
    rx_send(x);
    repeat (DEPTH + 2) tick();
    // R7 verification off, check byte equal to sync
    rx_tag = "R7";
    chk_en = 1'b0;
    rx_send(8'h02); rx_send(8'h33); rx_send(8'h44); rx_send(8'h02);
    rx_send(8'hAA); rx_send(8'hBB); rx_send(8'h02);
    rx_send(8'h02); rx_send(8'h61); rx_send(8'h62); rx_send(8'h00);
    rx_send(8'h03); tick();
    chk_en = 1'b1;
    rx_tag = "R4";

    // R8 transmit example frame
    tx_tag = "R8";
    tx_write(0, 8'h30); tick();
    tx_go(8'h95, 8'h0A, 8'h01);
    tx_drain();
    tx_go(8'h7E, 8'h01, 8'h00);
    tx_drain();
    // R9 full-depth frame under back-pressure
    tx_tag = "R9";
    for (int i = 0; i < DEPTH; i++) tx_write(i, 8'(8'hA0 + i * 3));
    tick();
    bp_on = 1'b1;
    tx_go(8'hC3, 8'h5A, 8'(DEPTH));
    tx_drain();
    bp_on = 1'b0;
    tick();
    // R10 start while busy is ignored
    tx_tag = "R10";
    tx_go(8'h11, 8'h22, 8'h02);
    tick();
    tx_go(8'h99, 8'h88, 8'h05);
    tx_drain();
    // R11 check byte still computed with verification off
    tx_tag = "R11";
    chk_en = 1'b0;
    tx_go(8'h44, 8'h55, 8'h01);
    tx_drain();
    chk_en = 1'b1;
    repeat (4) tick();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule